// File: doc/BRIEF.md
# Selectable-Source Countdown Timer

An 8-bit binary down-counter driven by one of four tick-enable inputs that a shared prescaler supplies. The tick rates are nominally 4096 Hz, 64 Hz, 1 Hz and one tick per minute. Software loads a start value. The block then counts that value down on the selected tick. Each time a period ends, it raises a sticky flag and restarts from the loaded value.

A small control register holds three fields: a run bit, an interrupt-style bit and a two-bit source select. The interrupt either tracks the flag as a steady level or gives one pulse per period. A pulse lasts until the next selected tick. On the slowest source it lasts a single clock. A loaded value of zero parks the timer: it does not count and it never sets the flag.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count reads 0, the flag and the interrupt are low, and the control readback is 4'b0011: run=0, style=0, select=3.
- R2: A count write loads the written value as both the live count and the reload value. The live value reads back on `count_rdata` one cycle later.
- R3: The control layout is bit 3 = run, bit 2 = style (0 level, 1 pulse) and bits 1:0 = select. Select value k picks `tick_i[k]`: 0 = 4096 Hz, 1 = 64 Hz, 2 = 1 Hz, 3 = 1/60 Hz. While running, each selected tick lowers a live count above 1 by exactly one. Ticks on unselected inputs leave the count unchanged.
- R4: A selected tick that finds the live count at 1 reloads the loaded value and sets the flag. A loaded value N therefore gives a period of N selected ticks.
- R5: With run=0, ticks change neither the count nor the flag.
- R6: With a loaded value of 0, the count stays 0 and the flag never sets, whatever ticks arrive.
- R7: The flag stays set until a `flag_clr` pulse. A clear in the same cycle as a period end leaves the flag set.
- R8: In level style (style=0) the interrupt equals the flag, including straight after a control write that selects level style.
- R9: In pulse style (style=1) the interrupt rises with each period end. For select 0 to 2 it falls at the next selected tick. For select 3 it falls after one clock. The flag is unaffected by the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 4 | One-clock tick enables, index = select value |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control write data {run, style, select} |
| count_we | input | 1 | Count/reload write strobe |
| count_wdata | input | 8 | Value to load |
| flag_clr | input | 1 | Clears the period flag |
| ctrl_rdata | output | 4 | Control register readback |
| count_rdata | output | 8 | Live countdown value |
| flag_o | output | 1 | Sticky period-end flag |
| irq_o | output | 1 | Interrupt, level or pulse style |

## Verification
The assertions check four rules on every cycle:
- A selected tick lowers a count above 1 by exactly one.
- A stopped timer holds its count.
- The flag stays set without a clear, and a zero load never raises it.
- In level style the interrupt matches the flag, and on the slowest source a pulse ends after one clock.

Only the bench's scenarios show the rest:
- the period length for each source and load value;
- the reload value after wrap;
- that unselected ticks are ignored;
- that a pulse on a faster source is held until the next selected tick;
- that a clear loses to a simultaneous period end.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_PULSE = 1'b1
  } irq_style_e;
endpackage

// File: rtl/cdt_ctrl_reg.sv
module cdt_ctrl_reg #(
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SELW+1:0] wdata,
  output logic [SELW+1:0] ctrl_q,
  output logic [SELW+1:0] ctrl_nxt
);
  localparam logic [SELW+1:0] RST_VAL = {2'b00, {SELW{1'b1}}};

  always_comb begin
    ctrl_nxt = we ? wdata : ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= RST_VAL;
    else     ctrl_q <= ctrl_nxt;
  end
endmodule

// File: rtl/cdt_src_mux.sv
module cdt_src_mux #(
  parameter int NSRC = 4,
  parameter int SELW = 2
) (
  input  logic [NSRC-1:0] tick_i,
  input  logic [SELW-1:0] sel,
  output logic            tick_sel
);
  logic [NSRC-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign hit[g] = tick_i[g] && (sel == SELW'(g));
    end
  endgenerate

  assign tick_sel = |hit;
endmodule

// File: rtl/cdt_down_cnt.sv
module cdt_down_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  output logic [CNT_W-1:0] live_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;

  assign step   = !load_we && run && tick && (reload_q != '0);
  assign expire = step && (live_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      reload_q <= '0;
    end else if (load_we) begin
      live_q   <= load_data;
      reload_q <= load_data;
    end else if (expire) begin
      live_q   <= reload_q;
    end else if (step) begin
      live_q   <= live_q - ONE;
    end
  end
endmodule

// File: rtl/cdt_flag_irq.sv
module cdt_flag_irq
  import cdt_pkg::*;
#(
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            expire,
  input  logic            clr,
  input  logic            tick_sel,
  input  logic [SELW-1:0] sel,
  input  irq_style_e      style_nxt,
  output logic            flag_q,
  output logic            irq_q
);
  localparam logic [SELW-1:0] SLOWEST = {SELW{1'b1}};

  logic pulse_q;
  logic flag_d;
  logic pulse_d;
  logic release_now;

  always_comb begin
    release_now = (sel == SLOWEST) ? 1'b1 : tick_sel;
    flag_d      = expire || (flag_q && !clr);
    pulse_d     = expire || (pulse_q && !release_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
      irq_q   <= (style_nxt == IRQ_PULSE) ? pulse_d : flag_d;
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NSRC  = 4,
  localparam int SELW = $clog2(NSRC),
  localparam int CTLW = SELW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  tick_i,
  input  logic             ctrl_we,
  input  logic [CTLW-1:0]  ctrl_wdata,
  input  logic             count_we,
  input  logic [CNT_W-1:0] count_wdata,
  input  logic             flag_clr,
  output logic [CTLW-1:0]  ctrl_rdata,
  output logic [CNT_W-1:0] count_rdata,
  output logic             flag_o,
  output logic             irq_o
);
  logic [CTLW-1:0]  ctrl_q;
  logic [CTLW-1:0]  ctrl_nxt;
  logic             tick_sel;
  logic             expire;
  logic [CNT_W-1:0] reload_val;
  irq_style_e       style_nxt;

  cdt_ctrl_reg #(.SELW(SELW)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt)
  );

  cdt_src_mux #(.NSRC(NSRC), .SELW(SELW)) u_mux (
    .tick_i(tick_i), .sel(ctrl_q[SELW-1:0]), .tick_sel(tick_sel)
  );

  cdt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl_q[SELW+1]), .tick(tick_sel),
    .load_we(count_we), .load_data(count_wdata),
    .live_q(count_rdata), .reload_q(reload_val), .expire(expire)
  );

  assign style_nxt = irq_style_e'(ctrl_nxt[SELW]);

  cdt_flag_irq #(.SELW(SELW)) u_flag (
    .clk(clk), .rst(rst), .expire(expire), .clr(flag_clr),
    .tick_sel(tick_sel), .sel(ctrl_q[SELW-1:0]), .style_nxt(style_nxt),
    .flag_q(flag_o), .irq_q(irq_o)
  );

  assign ctrl_rdata = ctrl_q;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int CNT_W = 8,
  parameter int CTLW  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_sel,
  input logic             expire,
  input logic             count_we,
  input logic             flag_clr,
  input logic [CTLW-1:0]  ctrl_rdata,
  input logic [CNT_W-1:0] count_rdata,
  input logic [CNT_W-1:0] reload_val,
  input logic             flag_o,
  input logic             irq_o
);
  localparam logic [CTLW-3:0] SLOWEST = '1;

  logic run;
  logic pulse_style;
  assign run         = ctrl_rdata[CTLW-1];
  assign pulse_style = ctrl_rdata[CTLW-2];

  // R3: one selected tick lowers a count above 1 by one
  assert_dec_R3: assert property (@(posedge clk) disable iff (rst)
    (run && tick_sel && !count_we && count_rdata > CNT_W'(1))
      |=> (count_rdata == $past(count_rdata) - CNT_W'(1)));

  // R5: a stopped timer holds its count
  assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !count_we) |=> $stable(count_rdata));

  // R6: a zero load never raises the flag
  assert_zero_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (reload_val == '0 && !count_we && !flag_o) |=> !flag_o);

  // R7: the flag is sticky without a clear
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_clr) |=> flag_o);

  // R8: in level style the interrupt matches the flag
  assert_level_follows_R8: assert property (@(posedge clk) disable iff (rst)
    !pulse_style |-> (irq_o == flag_o));

  // R9: on the slowest source a pulse lasts one clock
  assert_slow_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (pulse_style && ctrl_rdata[CTLW-3:0] == SLOWEST && irq_o && !expire)
      |=> !irq_o);
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W), .CTLW(CTLW)) u_chk (
  .clk(clk), .rst(rst), .tick_sel(tick_sel), .expire(expire),
  .count_we(count_we), .flag_clr(flag_clr), .ctrl_rdata(ctrl_rdata),
  .count_rdata(count_rdata), .reload_val(reload_val),
  .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tick_i = '0;
  logic       ctrl_we = 1'b0;
  logic [3:0] ctrl_wdata = '0;
  logic       count_we = 1'b0;
  logic [7:0] count_wdata = '0;
  logic       flag_clr = 1'b0;
  logic [3:0] ctrl_rdata;
  logic [7:0] count_rdata;
  logic       flag_o;
  logic       irq_o;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  cdt_timer uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .count_we(count_we), .count_wdata(count_wdata),
    .flag_clr(flag_clr), .ctrl_rdata(ctrl_rdata), .count_rdata(count_rdata),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_tick(input int idx);
    tick_i = 4'(1 << idx);
    step();
    tick_i = '0;
  endtask

  task automatic wr_ctrl(input bit run, input bit pulse, input int sel);
    ctrl_we    = 1'b1;
    ctrl_wdata = {run, pulse, 2'(sel)};
    step();
    ctrl_we    = 1'b0;
  endtask

  task automatic wr_count(input int v);
    count_we    = 1'b1;
    count_wdata = 8'(v);
    step();
    count_we    = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog R1 actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int ns[4] = '{1, 2, 3, 7};
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset state
    check("R1 count", count_rdata, 0);
    check("R1 flag", flag_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 ctrl", ctrl_rdata, 3);

    // R3, R4, R2, R8, R7: sweep over every source and several loads
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < 4; j++) begin
        int n = ns[j];
        wr_ctrl(1'b1, 1'b0, s);
        check("R3 ctrl readback", ctrl_rdata, 8 + s);
        wr_count(n);
        check("R2 load", count_rdata, n);
        do_tick((s + 1) % 4);
        check("R3 unselected tick", count_rdata, n);
        for (int k = 1; k < n; k++) begin
          do_tick(s);
          check("R3 decrement", count_rdata, n - k);
          check("R4 no early flag", flag_o, 0);
        end
        do_tick(s);
        check("R4 reload", count_rdata, n);
        check("R4 flag set", flag_o, 1);
        check("R8 irq level", irq_o, 1);
        step();
        check("R7 flag sticky", flag_o, 1);
        clr_flag();
        check("R7 flag cleared", flag_o, 0);
        check("R8 irq cleared", irq_o, 0);
      end
    end

    // R5: stopped timer ignores ticks
    wr_ctrl(1'b0, 1'b0, 1);
    wr_count(5);
    for (int k = 0; k < 3; k++) do_tick(1);
    check("R5 count held", count_rdata, 5);
    check("R5 no flag", flag_o, 0);

    // R6: zero load parks the timer
    wr_ctrl(1'b1, 1'b0, 0);
    wr_count(0);
    for (int k = 0; k < 4; k++) do_tick(0);
    check("R6 count zero", count_rdata, 0);
    check("R6 no flag", flag_o, 0);

    // R7: a clear loses to a period end in the same cycle
    wr_count(1);
    do_tick(0);
    check("R7 flag set", flag_o, 1);
    tick_i   = 4'b0001;
    flag_clr = 1'b1;
    step();
    tick_i   = '0;
    flag_clr = 1'b0;
    check("R7 set wins", flag_o, 1);
    clr_flag();
    check("R7 cleared", flag_o, 0);

    // R9: pulse style on a fast source
    wr_ctrl(1'b1, 1'b1, 1);
    wr_count(2);
    do_tick(1);
    check("R9 before end", irq_o, 0);
    do_tick(1);
    check("R9 pulse rises", irq_o, 1);
    check("R9 flag set", flag_o, 1);
    step();
    step();
    check("R9 pulse held", irq_o, 1);
    do_tick(1);
    check("R9 pulse falls on tick", irq_o, 0);
    check("R9 flag stays", flag_o, 1);

    // R8: switching to level style shows the pending flag at once
    wr_ctrl(1'b1, 1'b0, 1);
    check("R8 level after switch", irq_o, 1);
    clr_flag();

    // R9: pulse style on the slowest source
    wr_ctrl(1'b1, 1'b1, 3);
    wr_count(2);
    do_tick(3);
    do_tick(3);
    check("R9 slow pulse rises", irq_o, 1);
    step();
    check("R9 slow pulse one clock", irq_o, 0);
    check("R9 slow flag", flag_o, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule